// File: doc/BRIEF.md
# Biphase-Mark Stereo Audio Transmitter

This block serialises pairs of 16-bit audio samples into a self-clocking biphase-mark line. Each stereo frame consists of two 32-slot subframes, left then right. Every subframe opens with an 8-half-cell sync pattern. It then carries 8 zero slots, the sample in slots 12 to 27 with the least significant bit first, and a validity bit, a user bit, one channel-status bit and an even-parity bit. The 192 frames of a block each carry one channel-status bit. These bits are assembled from a few control fields.

The host pulses `sampleValid` with a new left/right pair at any time. The pair waits in a holding stage and becomes the active pair only at the next frame boundary. A subframe therefore never mixes two samples. If no new pair arrives, the last pair is sent again. `tickEn` is a clock enable at 128 times the sample rate, and each pulse advances the line by one half-cell. The line is held low when the transmitter is disabled, in pass-through, or in reset. Leaving any of these states restarts the stream at the first frame of a block.

Top module: `bmTx`

## Requirements
- R1: While `rstN` is low, `txEnable` is low or `passThru` is high, `lineOut` is 0 from the next clock. When the block becomes active again, it starts at half-cell 0 of the left subframe of block frame 0.
- R2: `lineOut` changes only on a clock where `tickEn` is high. Each subframe takes 64 `tickEn` pulses, with the left subframe first and the right subframe second.
- R3: Half-cells 0–7 of a subframe are driven directly with a sync pattern, MSB first. Left subframe of block frame 0: 11101000. Other left subframes: 11100010. Right subframes: 11100100.
- R4: In slots 4–31 the line toggles at the start of every slot, and toggles again at mid-slot when the slot's bit is 1.
- R5: Slots 12–27 carry the active sample, bit 0 in slot 12. The left sample goes in the left subframe and the right sample in the right subframe. Slots 4–11 are always 0.
- R6: If `mute` was high when the pair was taken, the audio slots are 0 and the validity slot (28) is 1. Otherwise validity is 0. The user slot (29) is always 0.
- R7: Slot 31 makes the number of ones across slots 4–31 even, so the line is low after the last half-cell of every subframe.
- R8: Slot 30 of both subframes of block frame n carries channel-status bit n. Bits 0–3 are `ctlFlags[0..3]`. Bits 8–14 are bits 0–6 of a category code: `catSel` 0 gives 0x00, 1 gives 0x4C, 2 gives 0x04 and 3 gives 0x2C. Bit 15 is `lFlag`. Bits 24/25 are `rateFlags[0]/[1]`, and bits 28/29 are `extraFlags[0]/[1]`. All other bits are 0.
- R9: A pair strobed while the block runs takes effect only from the next frame, together with `mute` sampled at that boundary, and the frame in progress is unchanged. While stopped, a strobed pair becomes active at once. Without a strobe, the previous pair repeats.
- R10: Frames are numbered 0–191 and then wrap, so frame 192 carries the block-start sync pattern again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Half-cell advance enable (128x sample rate) |
| txEnable | input | 1 | Transmitter enable |
| passThru | input | 1 | Pass-through mode, forces the line low |
| mute | input | 1 | Mute request, taken with each pair |
| sampleValid | input | 1 | One-cycle strobe for a new sample pair |
| sampleLeft | input | 16 | Left sample, two's complement |
| sampleRight | input | 16 | Right sample, two's complement |
| ctlFlags | input | 4 | Channel-status bits 0–3 |
| catSel | input | 2 | Category code selector |
| lFlag | input | 1 | Channel-status bit 15 |
| rateFlags | input | 2 | Channel-status bits 24 and 25 |
| extraFlags | input | 2 | Channel-status bits 28 and 29 |
| lineOut | output | 1 | Biphase-mark encoded line |

## Verification
A slip in the half-cell counter or the channel flag shows within one subframe. The sync pattern appears at the wrong place, the coding rule breaks, or the line is not low after 64 half-cells. A wrong frame counter shows as a misplaced block-start pattern or as channel-status bits taken from the wrong index. This can take up to a whole 192-frame block, so the stream is checked across a full block and one frame beyond it. A buffering fault shows as a right subframe carrying a pair that was strobed during the left subframe of the same frame.

// File: rtl/bmTxPkg.sv
package bmTxPkg;
  localparam int AUDIO_W    = 16;
  localparam int AUD_IDX_W  = $clog2(AUDIO_W);
  localparam int SLOT_CNT   = 32;
  localparam int SLOT_W     = $clog2(SLOT_CNT);
  localparam int HALF_CNT   = 2 * SLOT_CNT;
  localparam int HALF_W     = $clog2(HALF_CNT);
  localparam int FRAME_CNT  = 192;
  localparam int FRAME_W    = $clog2(FRAME_CNT);
  localparam int PRE_LEN    = 8;
  localparam int AUDIO_SLOT = 12;
  localparam int VAL_SLOT   = AUDIO_SLOT + AUDIO_W;
  localparam int USER_SLOT  = VAL_SLOT + 1;
  localparam int CS_SLOT    = VAL_SLOT + 2;
  localparam int PAR_SLOT   = VAL_SLOT + 3;
  localparam int CAT_W      = 7;

  localparam logic [PRE_LEN-1:0] SYNC_BLOCK = 8'b11101000;
  localparam logic [PRE_LEN-1:0] SYNC_LEFT  = 8'b11100010;
  localparam logic [PRE_LEN-1:0] SYNC_RIGHT = 8'b11100100;

  typedef struct packed {
    logic               clear;
    logic               step;
    logic               frameLoad;
    logic [HALF_W-1:0]  halfIdx;
    logic               chanSel;
    logic [FRAME_W-1:0] frameNo;
  } ctrlBus_t;
endpackage

// File: rtl/bmTxCtrl.sv
module bmTxCtrl
  import bmTxPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     tickEn,
  input  logic     txEnable,
  input  logic     passThru,
  output ctrlBus_t ctrlBus
);
  localparam logic [HALF_W-1:0]  HALF_LAST  = HALF_W'(HALF_CNT - 1);
  localparam logic [FRAME_W-1:0] FRAME_LAST = FRAME_W'(FRAME_CNT - 1);

  logic               running;
  logic [HALF_W-1:0]  halfIdx;
  logic               chanSel;
  logic [FRAME_W-1:0] frameNo;

  assign running = txEnable & ~passThru;

  always_ff @(posedge clk) begin
    if (!rstN || !running) begin
      halfIdx <= '0;
      chanSel <= 1'b0;
      frameNo <= '0;
    end else if (tickEn) begin
      halfIdx <= halfIdx + 1'b1;
      if (halfIdx == HALF_LAST) begin
        chanSel <= ~chanSel;
        if (chanSel)
          frameNo <= (frameNo == FRAME_LAST) ? '0 : frameNo + 1'b1;
      end
    end
  end

  always_comb begin
    ctrlBus.clear     = ~running;
    ctrlBus.step      = running & tickEn;
    ctrlBus.frameLoad = running & tickEn & chanSel & (halfIdx == HALF_LAST);
    ctrlBus.halfIdx   = halfIdx;
    ctrlBus.chanSel   = chanSel;
    ctrlBus.frameNo   = frameNo;
  end
endmodule

// File: rtl/bmTxData.sv
module bmTxData
  import bmTxPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlBus_t           ctrlBus,
  input  logic               sampleValid,
  input  logic [AUDIO_W-1:0] sampleLeft,
  input  logic [AUDIO_W-1:0] sampleRight,
  input  logic               mute,
  input  logic [3:0]         ctlFlags,
  input  logic [1:0]         catSel,
  input  logic               lFlag,
  input  logic [1:0]         rateFlags,
  input  logic [1:0]         extraFlags,
  output logic               lineOut
);
  logic [AUDIO_W-1:0] inWord   [2];
  logic [AUDIO_W-1:0] pendWord [2];
  logic [AUDIO_W-1:0] actWord  [2];
  logic pendValid, muteAct, loadNow;

  assign inWord[0] = sampleLeft;
  assign inWord[1] = sampleRight;
  assign loadNow   = ctrlBus.clear | ctrlBus.frameLoad;

  // Two-stage buffer per channel: holding word, then active word
  for (genvar c = 0; c < 2; c++) begin : g_chan
    always_ff @(posedge clk) begin
      if (!rstN) begin
        pendWord[c] <= '0;
        actWord[c]  <= '0;
      end else begin
        if (sampleValid) pendWord[c] <= inWord[c];
        if (loadNow && pendValid) actWord[c] <= pendWord[c];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      muteAct   <= 1'b0;
    end else begin
      pendValid <= sampleValid | (pendValid & ~loadNow);
      if (loadNow) muteAct <= mute;
    end
  end

  // Channel-status bit for the current frame
  logic [CAT_W-1:0]   catCode;
  logic [FRAME_W-1:0] catOff;
  logic               csBit;

  assign catOff = ctrlBus.frameNo - FRAME_W'(8);

  always_comb begin
    unique case (catSel)
      2'd0: catCode = 7'h00;
      2'd1: catCode = 7'h4C;
      2'd2: catCode = 7'h04;
      default: catCode = 7'h2C;
    endcase
    csBit = 1'b0;
    if (ctrlBus.frameNo < FRAME_W'(4))
      csBit = ctlFlags[ctrlBus.frameNo[1:0]];
    else if (ctrlBus.frameNo >= FRAME_W'(8) && ctrlBus.frameNo <= FRAME_W'(14))
      csBit = catCode[catOff[2:0]];
    else if (ctrlBus.frameNo == FRAME_W'(15))
      csBit = lFlag;
    else if (ctrlBus.frameNo == FRAME_W'(24) || ctrlBus.frameNo == FRAME_W'(25))
      csBit = rateFlags[ctrlBus.frameNo[0]];
    else if (ctrlBus.frameNo == FRAME_W'(28) || ctrlBus.frameNo == FRAME_W'(29))
      csBit = extraFlags[ctrlBus.frameNo[0]];
  end

  // Slot bit selection
  logic [SLOT_W-1:0]  slot;
  logic [SLOT_W-1:0]  audOff;
  logic [AUDIO_W-1:0] audio;
  logic               parity, dataBit;
  logic [PRE_LEN-1:0] syncPat;
  logic [2:0]         preIdx;
  logic               preBit, lineQ, lineNext;

  assign slot   = ctrlBus.halfIdx[HALF_W-1:1];
  assign audOff = slot - SLOT_W'(AUDIO_SLOT);
  assign audio  = muteAct ? '0 : actWord[ctrlBus.chanSel];
  assign parity = (^audio) ^ muteAct ^ csBit;

  always_comb begin
    dataBit = 1'b0;
    if (slot >= SLOT_W'(AUDIO_SLOT) && slot < SLOT_W'(VAL_SLOT))
      dataBit = audio[audOff[AUD_IDX_W-1:0]];
    else if (slot == SLOT_W'(VAL_SLOT))  dataBit = muteAct;
    else if (slot == SLOT_W'(USER_SLOT)) dataBit = 1'b0;
    else if (slot == SLOT_W'(CS_SLOT))   dataBit = csBit;
    else if (slot == SLOT_W'(PAR_SLOT))  dataBit = parity;
  end

  assign syncPat = ctrlBus.chanSel ? SYNC_RIGHT :
                   (ctrlBus.frameNo == '0) ? SYNC_BLOCK : SYNC_LEFT;
  assign preIdx  = 3'd7 - ctrlBus.halfIdx[2:0];
  assign preBit  = syncPat[preIdx];

  always_comb begin
    if (ctrlBus.halfIdx < HALF_W'(PRE_LEN)) lineNext = preBit;
    else if (!ctrlBus.halfIdx[0])           lineNext = ~lineQ;
    else                                    lineNext = dataBit ? ~lineQ : lineQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctrlBus.clear) lineQ <= 1'b0;
    else if (ctrlBus.step)      lineQ <= lineNext;
  end

  assign lineOut = lineQ;
endmodule

// File: rtl/bmTx.sv
module bmTx
  import bmTxPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               tickEn,
  input  logic               txEnable,
  input  logic               passThru,
  input  logic               mute,
  input  logic               sampleValid,
  input  logic [AUDIO_W-1:0] sampleLeft,
  input  logic [AUDIO_W-1:0] sampleRight,
  input  logic [3:0]         ctlFlags,
  input  logic [1:0]         catSel,
  input  logic               lFlag,
  input  logic [1:0]         rateFlags,
  input  logic [1:0]         extraFlags,
  output logic               lineOut
);
  ctrlBus_t ctrlBus;

  bmTxCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn),
    .txEnable(txEnable), .passThru(passThru), .ctrlBus(ctrlBus)
  );

  bmTxData u_data (
    .clk(clk), .rstN(rstN), .ctrlBus(ctrlBus),
    .sampleValid(sampleValid), .sampleLeft(sampleLeft), .sampleRight(sampleRight),
    .mute(mute), .ctlFlags(ctlFlags), .catSel(catSel), .lFlag(lFlag),
    .rateFlags(rateFlags), .extraFlags(extraFlags), .lineOut(lineOut)
  );
endmodule

// File: rtl/bmTxChecker.sv
module bmTxChecker
  import bmTxPkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               tickEn,
  input logic               txEnable,
  input logic               passThru,
  input logic               lineOut,
  input logic [HALF_W-1:0]  halfIdx,
  input logic [FRAME_W-1:0] frameNo
);
  logic run;
  assign run = txEnable & ~passThru;

  assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> !lineOut);

  assert_hold_between_ticks_R2: assert property (@(posedge clk) disable iff (!rstN)
    (run && !tickEn) |=> $stable(lineOut));

  assert_sync_opens_high_R3: assert property (@(posedge clk) disable iff (!rstN)
    (run && tickEn && halfIdx == '0) |=> lineOut);

  assert_subframe_ends_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    (run && tickEn && halfIdx == HALF_W'(HALF_CNT - 1)) |=> !lineOut);

  assert_frame_in_range_R10: assert property (@(posedge clk) disable iff (!rstN)
    frameNo < FRAME_W'(FRAME_CNT));
endmodule

bind bmTx bmTxChecker u_bmTxChecker (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .txEnable(txEnable),
  .passThru(passThru), .lineOut(lineOut),
  .halfIdx(ctrlBus.halfIdx), .frameNo(ctrlBus.frameNo)
);

// File: tb/test_bmTx.sv
module test_bmTx;
  logic clk = 1'b0;
  logic rstN = 1'b0, tickEn = 1'b0, txEnable = 1'b0, passThru = 1'b0;
  logic mute = 1'b0, sampleValid = 1'b0, lFlag = 1'b0;
  logic [15:0] sampleLeft = '0, sampleRight = '0;
  logic [3:0] ctlFlags = '0;
  logic [1:0] catSel = '0, rateFlags = '0, extraFlags = '0;
  logic lineOut;

  int nChecks = 0, nFails = 0;
  logic [63:0] cells;

  always #2 clk = ~clk;

  bmTx i_bmTx (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .txEnable(txEnable), .passThru(passThru),
    .mute(mute), .sampleValid(sampleValid), .sampleLeft(sampleLeft), .sampleRight(sampleRight),
    .ctlFlags(ctlFlags), .catSel(catSel), .lFlag(lFlag), .rateFlags(rateFlags),
    .extraFlags(extraFlags), .lineOut(lineOut)
  );

  // {mute, left, right}
  localparam int NVEC = 8;
  localparam logic [32:0] VEC [NVEC] = '{
    {1'b0, 16'h1234, 16'hABCD}, {1'b0, 16'h0000, 16'hFFFF},
    {1'b1, 16'h5A5A, 16'hA5A5}, {1'b0, 16'h8000, 16'h0001},
    {1'b0, 16'h7FFF, 16'h0F0F}, {1'b1, 16'hFFFF, 16'hFFFF},
    {1'b0, 16'hC3C3, 16'h0100}, {1'b0, 16'h0042, 16'hF00D}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic csRef(input int f);
    logic [6:0] cat;
    case (catSel)
      2'd0: cat = 7'h00;
      2'd1: cat = 7'h4C;
      2'd2: cat = 7'h04;
      default: cat = 7'h2C;
    endcase
    if (f < 4) return ctlFlags[f];
    if (f >= 8 && f <= 14) return cat[f-8];
    if (f == 15) return lFlag;
    if (f == 24 || f == 25) return rateFlags[f-24];
    if (f == 28 || f == 29) return extraFlags[f-28];
    return 1'b0;
  endfunction

  task automatic tick(input bit sv);
    @(negedge clk); tickEn = 1'b1; sampleValid = sv;
    @(negedge clk); tickEn = 1'b0; sampleValid = 1'b0;
  endtask

  task automatic runSub(input bit ch, input logic [15:0] expWord, input bit expMute,
                        input int f, input bit doStrobe, input logic [32:0] nxt, input string audTag);
    logic [7:0] pat;
    logic [31:0] got, exp;
    logic prev;
    bit codingOk;
    for (int h = 0; h < 64; h++) begin
      if (doStrobe && h == 32) begin
        sampleLeft = nxt[31:16]; sampleRight = nxt[15:0]; mute = nxt[32];
        tick(1'b1);
      end else tick(1'b0);
      cells[h] = lineOut;
      if (h == 20 && f == 3) begin
        repeat (3) @(negedge clk);
        chk(lineOut == cells[h], "R2 line held without tickEn", {31'd0, lineOut}, {31'd0, cells[h]});
      end
    end
    pat = ch ? 8'b11100100 : (f == 0 ? 8'b11101000 : 8'b11100010);
    chk(cells[7:0] == {pat[0], pat[1], pat[2], pat[3], pat[4], pat[5], pat[6], pat[7]},
        "R3 sync pattern", {24'd0, cells[7:0]}, {24'd0, pat[0], pat[1], pat[2], pat[3], pat[4], pat[5], pat[6], pat[7]});
    prev = cells[7];
    codingOk = 1'b1;
    got = '0;
    for (int s = 4; s < 32; s++) begin
      if (cells[2*s] == prev) codingOk = 1'b0;
      got[s] = cells[2*s] ^ cells[2*s+1];
      prev = cells[2*s+1];
    end
    chk(codingOk, "R4 cell boundary toggle", {31'd0, codingOk}, 32'd1);
    exp = '0;
    exp[27:12] = expMute ? 16'h0000 : expWord;
    exp[28] = expMute;
    exp[30] = csRef(f);
    exp[31] = ^exp[30:4];
    chk(got[11:4] == 8'h00, "R5 zero slots 4-11", {24'd0, got[11:4]}, 32'd0);
    chk(got[27:12] == exp[27:12], audTag, {16'd0, got[27:12]}, {16'd0, exp[27:12]});
    chk(got[29:28] == exp[29:28], "R6 validity/user", {30'd0, got[29:28]}, {30'd0, exp[29:28]});
    chk(got[30] == exp[30], "R8 channel status", {31'd0, got[30]}, {31'd0, exp[30]});
    chk(got[31] == exp[31] && cells[63] == 1'b0, "R7 parity", {31'd0, got[31]}, {31'd0, exp[31]});
  endtask

  task automatic runFrame(input int f, input logic [32:0] cur, input bit doStrobe, input logic [32:0] nxt);
    runSub(1'b0, cur[31:16], cur[32], f, doStrobe, nxt, "R5 left audio");
    runSub(1'b1, cur[15:0], cur[32], f, 1'b0, nxt, doStrobe ? "R9 right holds frame pair" : "R5 right audio");
  endtask

  initial begin
    // Reset with ticks applied
    for (int i = 0; i < 5; i++) tick(1'b0);
    chk(lineOut == 1'b0, "R1 low in reset", {31'd0, lineOut}, 32'd0);
    @(negedge clk); rstN = 1'b1;
    ctlFlags = 4'b1011; catSel = 2'd1; lFlag = 1'b1; rateFlags = 2'b10; extraFlags = 2'b01;
    // Strobe while stopped; ticks while disabled
    sampleLeft = VEC[0][31:16]; sampleRight = VEC[0][15:0]; mute = VEC[0][32];
    tick(1'b1);
    for (int i = 0; i < 4; i++) tick(1'b0);
    chk(lineOut == 1'b0, "R1 low while disabled", {31'd0, lineOut}, 32'd0);
    @(negedge clk); txEnable = 1'b1;
    // Table walk: each frame strobes the next pair mid-left-subframe
    for (int i = 0; i < NVEC; i++)
      runFrame(i, VEC[i], i < NVEC - 1, VEC[(i + 1) % NVEC]);
    // Repeat last pair through rest of block, then wrap (R10)
    for (int f = NVEC; f <= 192; f++)
      runFrame(f % 192, VEC[NVEC-1], 1'b0, VEC[0]);
    // Pass-through mid-frame forces low, then restart at block frame 0
    for (int i = 0; i < 10; i++) tick(1'b0);
    @(negedge clk); passThru = 1'b1;
    for (int i = 0; i < 3; i++) tick(1'b0);
    chk(lineOut == 1'b0, "R1 low in pass-through", {31'd0, lineOut}, 32'd0);
    catSel = 2'd3;
    @(negedge clk); passThru = 1'b0;
    for (int f = 0; f < 16; f++)
      runFrame(f, VEC[NVEC-1], 1'b0, VEC[0]);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #800000;
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule